// File: doc/BRIEF.md
# SMBus Slave Write-Command Decoder

This block sits behind a bit-level SMBus shifter and works purely on byte events. It sees decoded START and STOP conditions, each received byte, and the acknowledge slot that follows each byte. For every slot it decides whether to acknowledge. It checks the first byte of a transaction against its own 7-bit address and requires the write direction. It then classifies the write by how many data bytes follow the command byte before STOP.

The classes are as follows. A bare command in the RAM window loads the address pointer. A command with one data byte writes the 224-byte register RAM. A command with two data bytes hands a 16-bit address to the nonvolatile array controller. The erase command code with no data asks that controller to erase the page it was last given. Nothing is committed until STOP, so an interrupted transaction leaves no trace. While the controller reports busy, every byte is refused.

The state machine has seven states:

| State | Meaning |
|---|---|
| IDLE | waiting for START |
| ADDR | expecting the address byte |
| CMD | expecting the command byte |
| DATA0 | command held, no data yet |
| DATA1 | one data byte held |
| DATA2 | two data bytes held |
| DROP | transaction refused, waiting for START or STOP |

Transitions:
- START leads from any state to ADDR.
- STOP leads from any state to IDLE. It commits when it leaves DATA0, DATA1 or DATA2.
- A byte accepted in ADDR leads to CMD.
- A byte accepted in CMD leads to DATA0.
- A byte accepted in DATA0 leads to DATA1.
- A byte accepted in DATA1 leads to DATA2.
- A refused byte in ADDR, CMD, DATA0, DATA1 or DATA2 leads to DROP.
- IDLE and DROP stay where they are on a byte.

Top module: `smb_cmd_decoder`

## Requirements
- R1: After reset the pointer, the 16-bit nonvolatile address and every RAM byte read as zero. All strobes are low and no slot is acknowledged.
- R2: The address byte is acknowledged only when bits 7:1 equal the device address and bit 0 (direction) is 0. Otherwise it is refused, and every byte up to the next START is refused with no effect.
- R3: The command byte is acknowledged. A command 0x00–0xDF followed directly by STOP sets the pointer to the command value on that STOP edge. The pointer changes at no other time.
- R4: A command 0x00–0xDF with exactly one data byte writes that byte to RAM at the command address on the STOP edge. ram_we pulses for one cycle with the address and data.
- R5: A command with exactly two acknowledged data bytes pulses nv_load for one cycle on STOP. nv_addr holds first byte (bits 15:8) then second byte (bits 7:0) until the next load.
- R6: Command 0xFE followed directly by STOP pulses erase_req for one cycle and leaves the pointer unchanged.
- R7: A data byte after a command in 0xE0–0xFD is refused. The transaction is dropped with RAM and pointer untouched.
- R8: A third data byte is refused and the whole transaction is discarded: STOP commits nothing.
- R9: A repeated START at any point discards the bytes gathered so far and expects an address byte. A STOP before any data-complete state commits nothing.
- R10: A byte that arrives while nv_busy is high is refused and drops the transaction.
- R11: ack_now is high only during an ack-slot event, and then equals the decision for the latest byte.
- R12: rd_data shows the RAM byte at rd_addr for addresses below 224 and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_byte | input | 1 | a byte has been received |
| rx_byte | input | 8 | the received byte |
| ev_ack_slot | input | 1 | acknowledge slot in progress |
| nv_busy | input | 1 | nonvolatile controller busy |
| rd_addr | input | 8 | RAM read address |
| ack_now | output | 1 | drive ACK in this slot |
| rd_data | output | 8 | RAM read data |
| ptr_q | output | 8 | address pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| nv_load | output | 1 | 16-bit address load strobe |
| nv_addr | output | 16 | last loaded nonvolatile address |
| erase_req | output | 1 | page-erase request strobe |

## Verification
The assertions take for granted that the shifter raises at most one of START, STOP, byte and ack-slot in any cycle. They also assume each event lasts a single cycle. The stimulus drives every event as an isolated one-cycle pulse, followed by an idle or slot cycle, and changes nv_busy only between events. Both before and after the change, it keeps the event inputs mutually exclusive, including around refused bytes and repeated STARTs.

// File: rtl/smb_dec_pkg.sv
package smb_dec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA0,
        ST_DATA1,
        ST_DATA2,
        ST_DROP
    } dec_state_t;

    typedef struct packed {
        logic ptr_ld;
        logic ram_wr;
        logic nv_ld;
        logic erase;
    } commit_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_dec_fsm.sv
module smb_dec_fsm
    import smb_dec_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h5A,
    parameter int         RAM_DEPTH  = 224,
    parameter logic [7:0] ERASE_CODE = 8'hFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_start,
    input  logic                ev_stop,
    input  logic                ev_byte,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                nv_busy,
    output logic                ack_q,
    output commit_t             cm,
    output logic [BYTE_W-1:0]   cmd_q,
    output logic [BYTE_W-1:0]   d0_q,
    output logic [BYTE_W-1:0]   d1_q
);

    localparam logic [8:0] RAM_LIM = 9'(RAM_DEPTH);

    dec_state_t st, nxt;
    logic       ack_d;
    logic       take_cmd, take_d0, take_d1;
    logic       cmd_in_ram, cmd_reserved;

    assign cmd_in_ram   = {1'b0, cmd_q} < RAM_LIM;
    assign cmd_reserved = !cmd_in_ram && (cmd_q < ERASE_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ack_q <= 1'b0;
            cmd_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else begin
            st    <= nxt;
            ack_q <= ack_d;
            if (take_cmd) cmd_q <= rx_byte;
            if (take_d0)  d0_q  <= rx_byte;
            if (take_d1)  d1_q  <= rx_byte;
        end
    end

    always_comb begin
        nxt      = st;
        ack_d    = ack_q;
        cm       = '0;
        take_cmd = 1'b0;
        take_d0  = 1'b0;
        take_d1  = 1'b0;
        if (ev_start) begin
            nxt = ST_ADDR;
        end else if (ev_stop) begin
            unique case (st)
                ST_DATA0: begin
                    cm.ptr_ld = cmd_in_ram;
                    cm.erase  = (cmd_q == ERASE_CODE);
                end
                ST_DATA1: cm.ram_wr = cmd_in_ram;
                ST_DATA2: cm.nv_ld  = 1'b1;
                ST_IDLE, ST_ADDR, ST_CMD, ST_DROP: ;
                default: ;
            endcase
            nxt = ST_IDLE;
        end else if (ev_byte) begin
            ack_d = 1'b0;
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_DROP: nxt = ST_DROP;
                ST_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR && !rx_byte[0] && !nv_busy) begin
                        ack_d = 1'b1;
                        nxt   = ST_CMD;
                    end else begin
                        nxt = ST_DROP;
                    end
                end
                ST_CMD: begin
                    if (!nv_busy) begin
                        ack_d    = 1'b1;
                        take_cmd = 1'b1;
                        nxt      = ST_DATA0;
                    end else begin
                        nxt = ST_DROP;
                    end
                end
                ST_DATA0: begin
                    if (!nv_busy && !cmd_reserved) begin
                        ack_d   = 1'b1;
                        take_d0 = 1'b1;
                        nxt     = ST_DATA1;
                    end else begin
                        nxt = ST_DROP;
                    end
                end
                ST_DATA1: begin
                    if (!nv_busy) begin
                        ack_d   = 1'b1;
                        take_d1 = 1'b1;
                        nxt     = ST_DATA2;
                    end else begin
                        nxt = ST_DROP;
                    end
                end
                ST_DATA2: nxt = ST_DROP;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/smb_dec_ram.sv
module smb_dec_ram
    import smb_dec_pkg::*;
#(
    parameter int DEPTH = 224
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && (waddr == BYTE_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == BYTE_W'(i)) rdata = mem[i];
        end
    end

endmodule

// File: rtl/smb_dec_commit.sv
module smb_dec_commit
    import smb_dec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  commit_t               cm,
    input  logic [BYTE_W-1:0]     cmd_q,
    input  logic [BYTE_W-1:0]     d0_q,
    input  logic [BYTE_W-1:0]     d1_q,
    output logic [BYTE_W-1:0]     ptr_q,
    output logic                  ram_we,
    output logic [BYTE_W-1:0]     ram_waddr,
    output logic [BYTE_W-1:0]     ram_wdata,
    output logic                  nv_load,
    output logic [2*BYTE_W-1:0]   nv_addr,
    output logic                  erase_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
            nv_load   <= 1'b0;
            nv_addr   <= '0;
            erase_req <= 1'b0;
        end else begin
            ram_we    <= cm.ram_wr;
            nv_load   <= cm.nv_ld;
            erase_req <= cm.erase;
            if (cm.ptr_ld) ptr_q <= cmd_q;
            if (cm.ram_wr) begin
                ram_waddr <= cmd_q;
                ram_wdata <= d0_q;
            end
            if (cm.nv_ld) nv_addr <= {d0_q, d1_q};
        end
    end

endmodule

// File: rtl/smb_cmd_decoder.sv
module smb_cmd_decoder
    import smb_dec_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h5A,
    parameter int         RAM_DEPTH  = 224,
    parameter logic [7:0] ERASE_CODE = 8'hFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        ev_byte,
    input  logic [7:0]  rx_byte,
    input  logic        ev_ack_slot,
    input  logic        nv_busy,
    input  logic [7:0]  rd_addr,
    output logic        ack_now,
    output logic [7:0]  rd_data,
    output logic [7:0]  ptr_q,
    output logic        ram_we,
    output logic [7:0]  ram_waddr,
    output logic [7:0]  ram_wdata,
    output logic        nv_load,
    output logic [15:0] nv_addr,
    output logic        erase_req
);

    commit_t     cm;
    logic        ack_q;
    logic [7:0]  cmd_q, d0_q, d1_q;

    smb_dec_fsm #(
        .DEV_ADDR   (DEV_ADDR),
        .RAM_DEPTH  (RAM_DEPTH),
        .ERASE_CODE (ERASE_CODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_byte  (ev_byte),
        .rx_byte  (rx_byte),
        .nv_busy  (nv_busy),
        .ack_q    (ack_q),
        .cm       (cm),
        .cmd_q    (cmd_q),
        .d0_q     (d0_q),
        .d1_q     (d1_q)
    );

    smb_dec_ram #(
        .DEPTH (RAM_DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cm.ram_wr),
        .waddr (cmd_q),
        .wdata (d0_q),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    smb_dec_commit u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cm        (cm),
        .cmd_q     (cmd_q),
        .d0_q      (d0_q),
        .d1_q      (d1_q),
        .ptr_q     (ptr_q),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .nv_load   (nv_load),
        .nv_addr   (nv_addr),
        .erase_req (erase_req)
    );

    assign ack_now = ev_ack_slot & ack_q;

endmodule

// File: rtl/smb_cmd_decoder_chk.sv
module smb_cmd_decoder_chk #(
    parameter int RAM_DEPTH = 224
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       ev_byte,
    input logic       ev_ack_slot,
    input logic       nv_busy,
    input logic       ack_q,
    input logic [7:0] ptr_q,
    input logic       ram_we,
    input logic [7:0] ram_waddr,
    input logic       nv_load,
    input logic       erase_req
);

    p_events_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_byte, ev_ack_slot}));

    p_ptr_only_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_stop |=> $stable(ptr_q));

    p_ram_we_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(ev_stop));

    p_ram_addr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_waddr < 8'(RAM_DEPTH)));

    p_load_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nv_load |-> $past(ev_stop));

    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, nv_load, erase_req}));

    p_erase_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(ev_stop));

    p_busy_refuses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && nv_busy) |=> !ack_q);

endmodule

bind smb_cmd_decoder smb_cmd_decoder_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .ev_byte     (ev_byte),
    .ev_ack_slot (ev_ack_slot),
    .nv_busy     (nv_busy),
    .ack_q       (ack_q),
    .ptr_q       (ptr_q),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .nv_load     (nv_load),
    .erase_req   (erase_req)
);

// File: tb/smb_cmd_decoder_tb_top.sv
module smb_cmd_decoder_tb_top;

    localparam logic [6:0] ADDR7 = 7'h5A;
    localparam logic [7:0] WADDR = {ADDR7, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 0, ev_stop = 0, ev_byte = 0, ev_ack_slot = 0, nv_busy = 0;
    logic [7:0]  rx_byte = 0, rd_addr = 0;
    logic        ack_now, ram_we, nv_load, erase_req;
    logic [7:0]  rd_data, ptr_q, ram_waddr, ram_wdata;
    logic [15:0] nv_addr;

    int n_chk = 0, n_fail = 0;
    int erase_seen = 0;
    string cur_req = "R1";

    // behavioural reference state
    byte unsigned m_mem [224];
    byte unsigned m_q [$];
    bit          m_active = 0, m_dropped = 0, m_ack = 0;
    bit          m_we = 0, m_load = 0, m_erase = 0;
    byte unsigned m_ptr = 0, m_waddr = 0, m_wdata = 0;
    int unsigned m_nv = 0;

    always #4 clk = ~clk;

    smb_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_ack_slot(ev_ack_slot),
        .nv_busy(nv_busy), .rd_addr(rd_addr), .ack_now(ack_now), .rd_data(rd_data),
        .ptr_q(ptr_q), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .nv_load(nv_load), .nv_addr(nv_addr), .erase_req(erase_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mem_exp(input int a);
        return (a < 224) ? int'(m_mem[a]) : 0;
    endfunction

    // advance the reference by one clock edge using the inputs that were applied
    task automatic model_step();
        int cmd, n, pos;
        bit ok;
        m_we = 0; m_load = 0; m_erase = 0;
        if (ev_start) begin
            m_active = 1; m_dropped = 0; m_q.delete();
        end else if (ev_stop) begin
            if (m_active && !m_dropped && m_q.size() >= 2) begin
                cmd = m_q[1];
                n = m_q.size() - 2;
                if (n == 0 && cmd < 224) m_ptr = byte'(cmd);
                if (n == 0 && cmd == 'hFE) m_erase = 1;
                if (n == 1 && cmd < 224) begin
                    m_mem[cmd] = m_q[2]; m_we = 1; m_waddr = byte'(cmd); m_wdata = m_q[2];
                end
                if (n == 2) begin
                    m_load = 1; m_nv = {m_q[2], m_q[3]};
                end
            end
            m_active = 0;
        end else if (ev_byte) begin
            if (!m_active || m_dropped) begin
                m_ack = 0;
            end else begin
                pos = m_q.size();
                if (nv_busy) ok = 0;
                else if (pos == 0) ok = (rx_byte == WADDR);
                else if (pos == 1) ok = 1;
                else if (pos == 2) ok = !(m_q[1] >= 'hE0 && m_q[1] <= 'hFD);
                else if (pos == 3) ok = 1;
                else ok = 0;
                m_ack = ok;
                if (ok) m_q.push_back(rx_byte);
                else m_dropped = 1;
            end
        end
    endtask

    task automatic compare();
        chk("R3", "ptr", ptr_q, m_ptr);
        chk("R4", "ram_we", ram_we, m_we);
        if (m_we) begin
            chk("R4", "ram_waddr", ram_waddr, m_waddr);
            chk("R4", "ram_wdata", ram_wdata, m_wdata);
        end
        chk("R5", "nv_load", nv_load, m_load);
        chk("R5", "nv_addr", nv_addr, m_nv);
        chk("R6", "erase_req", erase_req, m_erase);
        if (erase_req) erase_seen++;
    endtask

    task automatic tick(input bit st, input bit sp, input bit by, input logic [7:0] d, input bit sl);
        @(negedge clk);
        model_step();
        compare();
        ev_start = st; ev_stop = sp; ev_byte = by; rx_byte = d; ev_ack_slot = sl;
        rd_addr = rd_addr + 8'd37;
        #1;
        chk("R11", "ack_now", ack_now, sl ? m_ack : 0);
        chk("R12", "rd_data", rd_data, mem_exp(rd_addr));
    endtask

    task automatic s_start(); tick(1, 0, 0, 0, 0); endtask
    task automatic s_stop();  tick(0, 1, 0, 0, 0); tick(0, 0, 0, 0, 0); endtask
    task automatic s_byte(input logic [7:0] b, input bit exp_ack);
        tick(0, 0, 1, b, 0);
        tick(0, 0, 0, 0, 1);
        chk(cur_req, "slot decision", ack_now, exp_ack);
    endtask

    task automatic peek(input string req, input logic [7:0] a, input int exp);
        tick(0, 0, 0, 0, 0);
        rd_addr = a; #1;
        chk(req, "ram read", rd_data, exp);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        int e0;
        foreach (m_mem[i]) m_mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        chk("R1", "ptr after reset", ptr_q, 0);
        chk("R1", "nv_addr after reset", nv_addr, 0);
        chk("R1", "ack_now after reset", ack_now, 0);
        peek("R1", 8'h44, 0);
        peek("R1", 8'hDF, 0);

        // R3 send byte sets pointer
        cur_req = "R3";
        s_start(); s_byte(WADDR, 1); s_byte(8'h10, 1); s_stop();
        chk("R3", "ptr after send byte", ptr_q, 8'h10);

        // R4 single byte writes
        cur_req = "R4";
        s_start(); s_byte(WADDR, 1); s_byte(8'h20, 1); s_byte(8'hA5, 1); s_stop();
        s_start(); s_byte(WADDR, 1); s_byte(8'hDF, 1); s_byte(8'h3C, 1); s_stop();
        peek("R4", 8'h20, 8'hA5);
        peek("R4", 8'hDF, 8'h3C);
        chk("R4", "ptr unchanged by write", ptr_q, 8'h10);

        // R5 word load
        cur_req = "R5";
        s_start(); s_byte(WADDR, 1); s_byte(8'h00, 1); s_byte(8'hF8, 1); s_byte(8'h40, 1); s_stop();
        chk("R5", "nv_addr word", nv_addr, 16'hF840);
        peek("R5", 8'h00, 0);

        // R6 erase request
        cur_req = "R6";
        e0 = erase_seen;
        s_start(); s_byte(WADDR, 1); s_byte(8'hFE, 1); s_stop();
        tick(0, 0, 0, 0, 0);
        chk("R6", "erase pulses", erase_seen - e0, 1);
        chk("R6", "ptr kept", ptr_q, 8'h10);

        // R7 reserved command with data
        cur_req = "R7";
        s_start(); s_byte(WADDR, 1); s_byte(8'hE5, 1); s_byte(8'h77, 0); s_stop();
        peek("R7", 8'hE5, 0);
        chk("R7", "ptr kept", ptr_q, 8'h10);

        // R8 third data byte
        cur_req = "R8";
        s_start(); s_byte(WADDR, 1); s_byte(8'h05, 1); s_byte(8'h12, 1);
        s_byte(8'h34, 1); s_byte(8'h56, 0); s_stop();
        chk("R8", "nv_addr kept", nv_addr, 16'hF840);
        peek("R8", 8'h05, 0);

        // R9 repeated start and early stop
        cur_req = "R9";
        s_start(); s_byte(WADDR, 1); s_byte(8'h30, 1); s_byte(8'h11, 1);
        s_start(); s_byte(WADDR, 1); s_byte(8'h31, 1); s_stop();
        chk("R9", "ptr after restart", ptr_q, 8'h31);
        peek("R9", 8'h30, 0);
        s_start(); s_byte(WADDR, 1); s_stop();
        chk("R9", "ptr after bare address", ptr_q, 8'h31);

        // R2 address mismatch and read direction
        cur_req = "R2";
        s_start(); s_byte({7'h5B, 1'b0}, 0); s_byte(8'h40, 0); s_stop();
        s_start(); s_byte({ADDR7, 1'b1}, 0); s_byte(8'h41, 0); s_byte(8'h99, 0); s_stop();
        chk("R2", "ptr untouched", ptr_q, 8'h31);
        peek("R2", 8'h41, 0);

        // R10 busy controller
        cur_req = "R10";
        nv_busy = 1;
        s_start(); s_byte(WADDR, 0); s_byte(8'h50, 0); s_stop();
        nv_busy = 0;
        s_start(); s_byte(WADDR, 1); s_byte(8'h51, 1);
        nv_busy = 1;
        s_byte(8'hBB, 0);
        nv_busy = 0;
        s_stop();
        peek("R10", 8'h51, 0);
        chk("R10", "ptr untouched", ptr_q, 8'h31);

        // R11 plus R4 once more after all that traffic
        cur_req = "R4";
        s_start(); s_byte(WADDR, 1); s_byte(8'h51, 1); s_byte(8'hC3, 1); s_stop();
        peek("R4", 8'h51, 8'hC3);
        peek("R12", 8'hF0, 0);

        repeat (3) tick(0, 0, 0, 0, 0);
        report();
    end

endmodule